// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a register-mapped watchdog that watches a free-running 64-bit system count supplied from outside. Software sets a reload interval and enables the timer. Each refresh arms an absolute deadline equal to the current count plus the interval. If the count reaches that deadline, the block first raises an alert meant to drive an interrupt, and it re-arms the deadline one interval later. If a second deadline passes with no refresh in between, the block raises a reset request. That request stays high until the block itself is reset.

Registers sit in two address frames on one simple write/read bus. Each frame has its own select line. The control frame holds the control/status word, the reload interval and the two halves of the 64-bit deadline. The refresh frame holds only a refresh location. Any write to that location rearms the timer, and so does any write to the control/status word. Both frames also return two fixed identification words. Reads are combinational, and a write takes effect at the clock edge where it is presented.

Top module: `gwd_timer`

## Requirements
- R1: After reset both stage outputs are low, and the control/status word, the reload interval and both deadline words read as 0.
- R2: In the control frame, 0x008 is a 32-bit read/write reload interval. 0x010 holds the low 32 bits of the deadline and 0x014 holds the high 32 bits; both are read/write.
- R3: At 0xFCC and 0xFD0, both frames return the parameter constants IMPL_CODE and DEV_CODE. Writes to these addresses change nothing.
- R4: In the control/status word at control-frame 0x000, bit 0 is the read/write enable. Bit 1 reads the alert stage and bit 2 reads the reset stage. Writing bits 1 and 2 has no effect.
- R5: A write to refresh-frame 0x000 counts as a refresh, whatever its data. A refresh loads the deadline with count + interval (using the count at that edge) and clears the alert.
- R6: A write to the control/status word is also a refresh.
- R7: When the timer is enabled, the alert is clear and the count is at or past the deadline, the alert rises at that edge. At the same edge the deadline is reloaded with count + interval.
- R8: If the alert is already set and the deadline passes again, the reset request rises. With a count that steps by one per clock, this happens exactly 2 x interval edges after the refresh edge, and the alert rises after 1 x interval.
- R9: Once raised, the reset request stays high through refreshes and disabling, and only block reset clears it.
- R10: While the timer is disabled, neither stage rises, even if the count is past the deadline.
- R11: With an interval of 0, the alert rises at the first edge after the enabling write, and the reset request rises at the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| count_i | input | 64 | Free-running system count |
| ctl_sel_i | input | 1 | Selects the control frame |
| rfr_sel_i | input | 1 | Selects the refresh frame |
| wr_i | input | 1 | Write strobe for the selected frame |
| addr_i | input | 12 | Byte offset within the frame |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected frame and offset |
| stage1_o | output | 1 | First-stage alert (interrupt request) |
| stage2_o | output | 1 | Second-stage reset request |

## Verification
The hardest case to reach is a second expiry that happens exactly on schedule. The count has to be walked through two full intervals, and no bus write may land in between, because any control write silently rearms the deadline. The bench therefore records the count at the enabling edge and lets its own counter step once per clock. It then counts edges to the expected alert edge and the expected reset edge, and samples one cycle before and at each of them. Separate sequences reach the other corner cases: an alert cleared by a refresh-frame write with arbitrary data, a deadline forced below the count while the timer is disabled, and a zero interval.

// File: rtl/gwd_timer.sv
module gwd_timer #(
  parameter int DW = 32,
  parameter int AW = 12,
  parameter logic [DW-1:0] IMPL_CODE = 32'h0201_043B,
  parameter logic [DW-1:0] DEV_CODE  = 32'h0000_5A17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2*DW-1:0] count_i,
  input  logic          ctl_sel_i,
  input  logic          rfr_sel_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          stage1_o,
  output logic          stage2_o
);
  localparam int CW = 2 * DW;
  localparam logic [AW-1:0] A_CTRL   = AW'('h000);
  localparam logic [AW-1:0] A_RELOAD = AW'('h008);
  localparam logic [AW-1:0] A_CMP_LO = AW'('h010);
  localparam logic [AW-1:0] A_CMP_HI = AW'('h014);
  localparam logic [AW-1:0] A_IMPL   = AW'('hFCC);
  localparam logic [AW-1:0] A_DEV    = AW'('hFD0);

  logic          en_q, s1_q, s2_q;
  logic [DW-1:0] reload_q;
  logic [CW-1:0] cmp_q;

  wire wr_ctl  = wr_i & ctl_sel_i;
  wire wr_rfr  = wr_i & rfr_sel_i;
  wire refresh = (wr_ctl | wr_rfr) & (addr_i == A_CTRL);
  wire expired = en_q & (count_i >= cmp_q);
  wire [CW-1:0] next_cmp = count_i + CW'(reload_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      s1_q     <= 1'b0;
      s2_q     <= 1'b0;
      reload_q <= '0;
      cmp_q    <= '0;
    end else begin
      if (wr_ctl && addr_i == A_CTRL)   en_q     <= wdata_i[0];
      if (wr_ctl && addr_i == A_RELOAD) reload_q <= wdata_i;
      if (refresh) begin
        cmp_q <= next_cmp;
        s1_q  <= 1'b0;
      end else if (wr_ctl && addr_i == A_CMP_LO) begin
        cmp_q[DW-1:0] <= wdata_i;
      end else if (wr_ctl && addr_i == A_CMP_HI) begin
        cmp_q[CW-1:DW] <= wdata_i;
      end else if (expired) begin
        if (!s1_q) begin
          s1_q  <= 1'b1;
          cmp_q <= next_cmp;
        end else begin
          s2_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ctl_sel_i) begin
      case (addr_i)
        A_CTRL:   rdata_o = {{(DW-3){1'b0}}, s2_q, s1_q, en_q};
        A_RELOAD: rdata_o = reload_q;
        A_CMP_LO: rdata_o = cmp_q[DW-1:0];
        A_CMP_HI: rdata_o = cmp_q[CW-1:DW];
        A_IMPL:   rdata_o = IMPL_CODE;
        A_DEV:    rdata_o = DEV_CODE;
        default:  rdata_o = '0;
      endcase
    end else if (rfr_sel_i) begin
      case (addr_i)
        A_IMPL:  rdata_o = IMPL_CODE;
        A_DEV:   rdata_o = DEV_CODE;
        default: rdata_o = '0;
      endcase
    end
  end

  assign stage1_o = s1_q;
  assign stage2_o = s2_q;
endmodule

// File: rtl/gwd_timer_chk.sv
module gwd_timer_chk #(
  parameter int DW = 32,
  parameter int AW = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2*DW-1:0] count_i,
  input logic            ctl_sel_i,
  input logic            rfr_sel_i,
  input logic            wr_i,
  input logic [AW-1:0]   addr_i,
  input logic            stage1_o,
  input logic            stage2_o,
  input logic            en_q,
  input logic [2*DW-1:0] cmp_q
);
  a_r9_stage2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stage2_o |=> stage2_o);

  a_r8_stage2_after_stage1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage2_o) |-> $past(stage1_o));

  a_r10_off_no_stage1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !$rose(stage1_o));

  a_r10_off_no_stage2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !$rose(stage2_o));

  a_r5_refresh_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && rfr_sel_i && addr_i == '0) |=> !stage1_o);

  a_r6_ctrl_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && ctl_sel_i && addr_i == '0) |=> !stage1_o);

  a_r7_rise_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage1_o) |-> $past(count_i >= cmp_q));
endmodule

bind gwd_timer gwd_timer_chk #(.DW(DW), .AW(AW)) u_gwd_timer_chk (
  .clk(clk), .rst_n(rst_n), .count_i(count_i), .ctl_sel_i(ctl_sel_i),
  .rfr_sel_i(rfr_sel_i), .wr_i(wr_i), .addr_i(addr_i),
  .stage1_o(stage1_o), .stage2_o(stage2_o), .en_q(en_q), .cmp_q(cmp_q)
);

// File: tb/test_gwd_timer.sv
`timescale 1ns/1ps
module test_gwd_timer;
  localparam logic [31:0] IMPL = 32'h0201_043B;
  localparam logic [31:0] DEV  = 32'h0000_5A17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt = 64'd1000;
  logic        ctl_sel = 1'b0, rfr_sel = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        stage1, stage2;
  logic [63:0] last_cnt;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  gwd_timer i_gwd_timer (
    .clk(clk), .rst_n(rst_n), .count_i(cnt), .ctl_sel_i(ctl_sel),
    .rfr_sel_i(rfr_sel), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .stage1_o(stage1), .stage2_o(stage2)
  );

  always #2.5 clk = ~clk;
  always @(negedge clk) cnt <= cnt + 64'd1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic ctl, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    ctl_sel = ctl; rfr_sel = !ctl; addr = a; wdata = d; wr = 1'b1;
    #1 last_cnt = cnt;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; ctl_sel = 1'b0; rfr_sel = 1'b0;
  endtask

  task automatic bus_rd(input logic ctl, input logic [11:0] a, output logic [31:0] d);
    ctl_sel = ctl; rfr_sel = !ctl; addr = a;
    #0.5 d = rdata;
    ctl_sel = 1'b0; rfr_sel = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1 stage1", stage1, 0);
    chk("R1 stage2", stage2, 0);
    bus_rd(1, 12'h000, d); chk("R1 ctrl", d, 0);
    bus_rd(1, 12'h008, d); chk("R1 reload", d, 0);
    bus_rd(1, 12'h010, d); chk("R1 cmp lo", d, 0);
    bus_rd(1, 12'h014, d); chk("R1 cmp hi", d, 0);
  endtask

  task automatic t_ids();
    logic [31:0] d;
    for (int f = 0; f < 2; f++) begin
      bus_rd(f[0], 12'hFCC, d); chk("R3 impl", d, IMPL);
      bus_rd(f[0], 12'hFD0, d); chk("R3 dev", d, DEV);
      bus_wr(f[0], 12'hFCC, 32'hFFFF_FFFF);
      bus_wr(f[0], 12'hFD0, 32'h0);
      bus_rd(f[0], 12'hFCC, d); chk("R3 impl after write", d, IMPL);
      bus_rd(f[0], 12'hFD0, d); chk("R3 dev after write", d, DEV);
    end
  endtask

  task automatic t_regs();
    logic [31:0] d;
    do_reset();
    bus_wr(1, 12'h008, 32'h1234_5678);
    bus_rd(1, 12'h008, d); chk("R2 reload", d, 32'h1234_5678);
    bus_wr(1, 12'h010, 32'hAAAA_5555);
    bus_wr(1, 12'h014, 32'h0000_0007);
    bus_rd(1, 12'h010, d); chk("R2 cmp lo", d, 32'hAAAA_5555);
    bus_rd(1, 12'h014, d); chk("R2 cmp hi", d, 32'h0000_0007);
  endtask

  task automatic t_status_ro();
    logic [31:0] d;
    logic [63:0] e;
    do_reset();
    bus_wr(1, 12'h000, 32'h6);
    bus_rd(1, 12'h000, d); chk("R4 status bits read-only", d, 0);
    chk("R4 no stage1", stage1, 0);
    bus_wr(1, 12'h008, 32'd1000);
    bus_wr(1, 12'h000, 32'h7);
    e = last_cnt + 64'd1000;
    bus_rd(1, 12'h000, d); chk("R4 enable only", d, 1);
    bus_rd(1, 12'h010, d); chk("R6 ctrl write rearms lo", d, e[31:0]);
    bus_rd(1, 12'h014, d); chk("R6 ctrl write rearms hi", d, e[63:32]);
  endtask

  task automatic t_escalate();
    logic [31:0] d;
    logic [63:0] c;
    do_reset();
    bus_wr(1, 12'h008, 32'd5);
    bus_wr(1, 12'h000, 32'h1);
    c = last_cnt;
    repeat (4) @(negedge clk);
    chk("R7 no alert before interval", stage1, 0);
    @(negedge clk);
    chk("R7 alert at interval", stage1, 1);
    bus_rd(1, 12'h000, d); chk("R4 status alert", d, 3);
    bus_rd(1, 12'h010, d); chk("R7 deadline reloaded", d, 32'(c + 64'd10));
    repeat (4) @(negedge clk);
    chk("R8 no reset before 2x", stage2, 0);
    @(negedge clk);
    chk("R8 reset at 2x", stage2, 1);
    bus_wr(0, 12'h000, 32'h1234_0000);
    chk("R9 refresh clears alert", stage1, 0);
    chk("R9 reset held after refresh", stage2, 1);
    bus_wr(1, 12'h000, 32'h0);
    repeat (3) @(negedge clk);
    chk("R9 reset held after disable", stage2, 1);
    bus_rd(1, 12'h000, d); chk("R9 status", d, 4);
    do_reset();
    chk("R9 cleared by block reset", stage2, 0);
  endtask

  task automatic t_refresh();
    logic [31:0] d;
    logic [63:0] c2;
    do_reset();
    bus_wr(1, 12'h008, 32'd20);
    bus_wr(1, 12'h000, 32'h1);
    repeat (20) @(negedge clk);
    chk("R7 alert before refresh", stage1, 1);
    bus_wr(0, 12'h000, 32'hDEAD_BEEF);
    c2 = last_cnt;
    chk("R5 refresh clears alert", stage1, 0);
    bus_rd(1, 12'h010, d); chk("R5 refresh rearms deadline", d, 32'(c2 + 64'd20));
    repeat (19) @(negedge clk);
    chk("R5 quiet until new deadline", stage1, 0);
    @(negedge clk);
    chk("R5 alert at new deadline", stage1, 1);
    chk("R5 no reset", stage2, 0);
  endtask

  task automatic t_disable();
    do_reset();
    bus_wr(1, 12'h008, 32'd3);
    bus_wr(1, 12'h000, 32'h1);
    bus_wr(1, 12'h000, 32'h0);
    bus_wr(1, 12'h010, 32'h0);
    bus_wr(1, 12'h014, 32'h0);
    repeat (20) @(negedge clk);
    chk("R10 no alert when disabled", stage1, 0);
    chk("R10 no reset when disabled", stage2, 0);
  endtask

  task automatic t_zero();
    do_reset();
    bus_wr(1, 12'h000, 32'h1);
    chk("R11 no alert at enabling edge", stage1, 0);
    @(negedge clk);
    chk("R11 alert next edge", stage1, 1);
    chk("R11 no reset yet", stage2, 0);
    @(negedge clk);
    chk("R11 reset following edge", stage2, 1);
  endtask

  initial begin
    t_reset();
    t_ids();
    t_regs();
    t_status_ro();
    t_escalate();
    t_refresh();
    t_disable();
    t_zero();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule